// File: doc/BRIEF.md
# Interpolated Magnification Lookup

This block turns a normalised squared radius product (the lens constant times the squared distance from the distortion centre, scaled so that 0 to 1 maps onto a 16-bit code) into a radial magnification factor. A distortion-correction pipeline uses this factor to scale output coordinates back into the distorted source image.

The factor is found from a coarse table and then refined. The table lives in a dual-port on-chip ROM, and its contents are computed at elaboration from the fixed-point solution of M = 1/(1 + x·M²). The upper bits of the input pick a table entry. Both that entry and its upper neighbour are read in the same cycle, one through each port. A signed linear interpolation driven by the lower input bits then produces the result.

M always lies between one half and one, so its leading bit is always set. The table therefore stores only the bits below it, and the block puts the leading bit back on output. The block accepts one request per clock and returns one result per clock, each tagged by a valid flag that travels with it.

Top module: `mag_interp_lut`

## Requirements
- R1: Table entry i (0 to 256) holds round(M(i/256)·2^18) − 2^17, clamped to the range 0 to 131071. M(x) is the converged solution of M = 1/(1 + x·M²).
- R2: Bits [15:8] of the input select the base entry. Bits [7:0] are the interpolation fraction, in units of 1/256.
- R3: The stored-field result equals base + floor(((next − base) · fraction) / 256), where next is the entry one above the base. The result therefore lies between base and next, inclusive.
- R4: Entries decrease with the index, so the slope is negative. The difference and the product are signed, and negative corrections are floored rather than truncated toward zero.
- R5: The output is 18 bits wide. Bit 17 is always 1 for a valid result, and the whole word equals M·2^18.
- R6: With base index 255, the next entry comes from guard entry 256, which holds M(1.0). No read goes past the end of the table.
- R7: A request sampled at rising edge N appears on the output with the valid flag set just after rising edge N+2.
- R8: Requests on consecutive clocks give results on consecutive clocks. A clock with no request gives a clock with the valid flag low.
- R9: Synchronous active-high reset clears the valid flag and drops every request in flight.
- R10: A fraction of zero returns the selected entry exactly, with the leading bit restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| in_kr | input | 16 | Normalised k·r² code |
| out_valid | output | 1 | Result present this cycle |
| out_mag | output | 18 | Magnification, M·2^18 |

## Verification
The hardest case to reach from the ports is the guard read. It needs an input whose upper byte is all ones together with a large fraction, so that the correction comes from the entry beyond the last base entry. A second hard case is a reset that arrives while the pipeline is full: results already in flight must disappear rather than come out later. The stimulus walks every base index at fraction zero and fraction 255, adds the extreme codes 0x0000 and 0xFFFF, and then runs random bursts with gaps. It also asserts reset in the middle of a back-to-back burst and compares the block against a behavioural model on every clock.

// File: rtl/mag_lut_pkg.sv
package mag_lut_pkg;

  localparam int KR_W  = 16;
  localparam int IDX_W = 8;
  localparam int ENT_W = 17;

  // Solve M = 1/(1 + x*M^2) by fixed-point iteration for x = idx / 2^idx_w.
  // Scale by 2^(ent_w+1), round to nearest, then drop the implicit leading one.
  function automatic int mag_entry(int idx, int idx_w, int ent_w);
    real x;
    real m;
    real scaled;
    int  q;
    x = real'(idx) / real'(64'd1 << idx_w);
    m = 1.0;
    for (int it = 0; it < 100; it++) m = 1.0 / (1.0 + x * m * m);
    scaled = m * real'(64'd1 << (ent_w + 1));
    q = $rtoi(scaled + 0.5) - (1 << ent_w);
    if (q > (1 << ent_w) - 1) q = (1 << ent_w) - 1;
    if (q < 0) q = 0;
    return q;
  endfunction

endpackage

// File: rtl/mag_tab_rd.sv
module mag_tab_rd #(
  parameter int KR_W  = mag_lut_pkg::KR_W,
  parameter int IDX_W = mag_lut_pkg::IDX_W,
  parameter int ENT_W = mag_lut_pkg::ENT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_v,
  input  logic [KR_W-1:0]        req_kr,
  output logic                   rd_v,
  output logic [KR_W-IDX_W-1:0]  rd_frac,
  output logic [ENT_W-1:0]       rd_base,
  output logic [ENT_W-1:0]       rd_next
);
  localparam int FRAC_W = KR_W - IDX_W;
  localparam int N_ENT  = (1 << IDX_W) + 1;  // includes the guard entry

  logic [ENT_W-1:0] rom [N_ENT];

  initial begin
    for (int i = 0; i < N_ENT; i++)
      rom[i] = ENT_W'(mag_lut_pkg::mag_entry(i, IDX_W, ENT_W));
  end

  logic [IDX_W:0] addr_a;
  logic [IDX_W:0] addr_b;
  assign addr_a = {1'b0, req_kr[KR_W-1 -: IDX_W]};
  assign addr_b = addr_a + 1'b1;

  // Two read ports of one ROM, no reset on the data path.
  always_ff @(posedge clk) begin
    rd_base <= rom[addr_a];
    rd_next <= rom[addr_b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v    <= 1'b0;
      rd_frac <= '0;
    end else begin
      rd_v    <= req_v;
      rd_frac <= req_kr[FRAC_W-1:0];
    end
  end

  p_req_to_rd_r7: assert property (@(posedge clk) disable iff (rst) req_v |=> rd_v);
  p_gap_rd_r8:    assert property (@(posedge clk) disable iff (rst) !req_v |=> !rd_v);
  p_tab_desc_r4:  assert property (@(posedge clk) disable iff (rst) rd_v |-> rd_next <= rd_base);

endmodule

// File: rtl/mag_slope_mul.sv
module mag_slope_mul #(
  parameter int ENT_W  = mag_lut_pkg::ENT_W,
  parameter int FRAC_W = mag_lut_pkg::KR_W - mag_lut_pkg::IDX_W,
  localparam int PROD_W = ENT_W + FRAC_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_v,
  input  logic [FRAC_W-1:0]        rd_frac,
  input  logic [ENT_W-1:0]         rd_base,
  input  logic [ENT_W-1:0]         rd_next,
  output logic                     mv,
  output logic signed [PROD_W-1:0] m_prod,
  output logic [ENT_W-1:0]         m_base,
  output logic [ENT_W-1:0]         m_next
);
  logic signed [ENT_W:0]      slope;
  logic signed [PROD_W-1:0]   prod;

  assign slope = $signed({1'b0, rd_next}) - $signed({1'b0, rd_base});
  assign prod  = slope * $signed({1'b0, rd_frac});

  always_ff @(posedge clk) begin
    m_prod <= prod;
    m_base <= rd_base;
    m_next <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (rst) mv <= 1'b0;
    else     mv <= rd_v;
  end

  p_rd_to_mul_r7: assert property (@(posedge clk) disable iff (rst) rd_v |=> mv);
  p_neg_prod_r4:  assert property (@(posedge clk) disable iff (rst)
                    (mv && (m_next < m_base)) |-> (m_prod <= 0));

endmodule

// File: rtl/mag_interp_out.sv
module mag_interp_out #(
  parameter int ENT_W  = mag_lut_pkg::ENT_W,
  parameter int FRAC_W = mag_lut_pkg::KR_W - mag_lut_pkg::IDX_W,
  localparam int PROD_W = ENT_W + FRAC_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mv,
  input  logic signed [PROD_W-1:0] m_prod,
  input  logic [ENT_W-1:0]         m_base,
  input  logic [ENT_W-1:0]         m_next,
  output logic                     out_v,
  output logic [ENT_W:0]           out_m
);
  logic [ENT_W-1:0] corr;
  logic [ENT_W-1:0] sum;

  // Arithmetic shift floors negative corrections; the true sum lies in range,
  // so modular addition on ENT_W bits is exact.
  assign corr = ENT_W'(m_prod >>> FRAC_W);
  assign sum  = m_base + corr;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_m <= '0;
    end else begin
      out_v <= mv;
      out_m <= {1'b1, sum};
    end
  end

  p_mul_to_out_r7: assert property (@(posedge clk) disable iff (rst) mv |=> out_v);
  p_bounded_r3:    assert property (@(posedge clk) disable iff (rst)
                     out_v |-> (out_m[ENT_W-1:0] <= ($past(m_base) > $past(m_next) ? $past(m_base) : $past(m_next))
                            &&  out_m[ENT_W-1:0] >= ($past(m_base) < $past(m_next) ? $past(m_base) : $past(m_next))));
  p_lead_bit_r5:   assert property (@(posedge clk) disable iff (rst) out_v |-> out_m[ENT_W]);

  // m_next feeds only the checks above
  logic unused_next;
  assign unused_next = ^m_next;

endmodule

// File: rtl/mag_interp_lut.sv
module mag_interp_lut #(
  parameter int KR_W  = mag_lut_pkg::KR_W,
  parameter int IDX_W = mag_lut_pkg::IDX_W,
  parameter int ENT_W = mag_lut_pkg::ENT_W,
  localparam int FRAC_W = KR_W - IDX_W,
  localparam int PROD_W = ENT_W + FRAC_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [KR_W-1:0] in_kr,
  output logic            out_valid,
  output logic [ENT_W:0]  out_mag
);
  logic                     rd_v;
  logic [FRAC_W-1:0]        rd_frac;
  logic [ENT_W-1:0]         rd_base;
  logic [ENT_W-1:0]         rd_next;
  logic                     mv;
  logic signed [PROD_W-1:0] m_prod;
  logic [ENT_W-1:0]         m_base;
  logic [ENT_W-1:0]         m_next;

  mag_tab_rd #(.KR_W(KR_W), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_rd (
    .clk(clk), .rst(rst), .req_v(in_valid), .req_kr(in_kr),
    .rd_v(rd_v), .rd_frac(rd_frac), .rd_base(rd_base), .rd_next(rd_next));

  mag_slope_mul #(.ENT_W(ENT_W), .FRAC_W(FRAC_W)) u_mul (
    .clk(clk), .rst(rst), .rd_v(rd_v), .rd_frac(rd_frac),
    .rd_base(rd_base), .rd_next(rd_next),
    .mv(mv), .m_prod(m_prod), .m_base(m_base), .m_next(m_next));

  mag_interp_out #(.ENT_W(ENT_W), .FRAC_W(FRAC_W)) u_out (
    .clk(clk), .rst(rst), .mv(mv), .m_prod(m_prod), .m_base(m_base),
    .m_next(m_next), .out_v(out_valid), .out_m(out_mag));

  p_reset_clear_r9: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

// File: tb/test_mag_interp_lut.sv
module test_mag_interp_lut;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_kr = '0;
  logic        out_valid;
  logic [17:0] out_mag;

  always #4 clk = ~clk;  // 125 MHz

  mag_interp_lut i_mag_interp_lut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kr(in_kr),
    .out_valid(out_valid), .out_mag(out_mag));

  int    n_cmp = 0;
  int    n_bad = 0;
  int    tab [0:256];
  bit    ev [0:2];
  int    ed [0:2];
  string et [0:2];

  // Reference table from R1, solved independently with more iterations.
  function automatic int ref_entry(int i);
    real x, m;
    int  q;
    x = real'(i) / 256.0;
    m = 1.0;
    for (int it = 0; it < 200; it++) m = 1.0 / (1.0 + x * m * m);
    q = $rtoi(m * 262144.0 + 0.5) - 131072;
    if (q > 131071) q = 131071;
    if (q < 0) q = 0;
    return q;
  endfunction

  // R2, R3, R4, R5, R6
  function automatic int ref_mag(logic [15:0] x);
    int hi, lo, d;
    hi = int'(x[15:8]);
    lo = int'(x[7:0]);
    d  = tab[hi+1] - tab[hi];
    return 131072 + tab[hi] + ((d * lo) >>> 8);
  endfunction

  task automatic check(bit c, string tag, int act, int exp);
    n_cmp++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: compare at the falling edge, then drive the next request.
  task automatic step(bit v, logic [15:0] x, string tag);
    @(negedge clk);
    check(out_valid == ev[2], {tag, " valid (R7/R8)"}, int'(out_valid), int'(ev[2]));
    if (ev[2] && out_valid)
      check(int'(out_mag) == ed[2], et[2], int'(out_mag), ed[2]);
    ev[2] = ev[1]; ed[2] = ed[1]; et[2] = et[1];
    ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
    in_valid = v;
    in_kr    = x;
    ev[0] = v;
    ed[0] = v ? ref_mag(x) : 0;
    et[0] = tag;
  endtask

  task automatic do_reset(int cycles);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) ev[i] = 1'b0;
    for (int i = 0; i < cycles; i++) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset clears valid", int'(out_valid), 0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i <= 256; i++) tab[i] = ref_entry(i);
    for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ed[i] = 0; et[i] = ""; end
    do_reset(4);

    // R10 / R1: every entry exactly, fraction zero
    for (int i = 0; i < 256; i++) step(1'b1, {i[7:0], 8'h00}, "R10 R1 exact entry");
    // R3 / R4: full fraction on every index, slope negative
    for (int i = 0; i < 256; i++) step(1'b1, {i[7:0], 8'hFF}, "R3 R4 max fraction");
    // R6: guard entry reads at top index
    step(1'b1, 16'hFF80, "R6 guard half");
    step(1'b1, 16'hFFFF, "R6 guard full");
    // R5: extreme codes
    step(1'b1, 16'h0000, "R5 zero input");
    step(1'b1, 16'h0001, "R5 tiny fraction");
    // R8: gaps between requests
    for (int i = 0; i < 40; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      step(i[0], r, "R8 gapped");
    end
    // R2 / R3: random back-to-back
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      step(1'b1, r, "R2 R3 random");
    end
    // R9: reset mid-burst drops in-flight requests
    step(1'b1, 16'h1234, "R9 dropped");
    step(1'b1, 16'h5678, "R9 dropped");
    do_reset(2);
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0, "R9 after reset");
    step(1'b1, 16'hABCD, "R7 after reset");
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, "R7 drain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule